// File: doc/BRIEF.md
# Configuration Register Target with Shadow Copy over I2C

This block is an I2C target that holds a small bank of byte-wide configuration registers. An internal shadow array stands in for nonvolatile storage. Each byte moved between the bank and the shadow array takes a parameterised number of clock cycles. A bus master reaches the bank with write-type frames and read frames. A single command byte chooses among four actions: writing registers, saving the whole bank into the shadow array, restoring the bank from the shadow array, or nothing. The surrounding logic reads any register combinationally through a side port.

Every write-type frame starts with the 7-bit target address and R/W = 0, followed by the command byte. A save or restore frame holds only those two bytes, and the copy begins at STOP. While a copy runs, `busy` is high and the target leaves its own address unacknowledged. A read frame returns a fixed identification byte first, and then registers taken in turn from an internal pointer. Leaving reset starts a restore automatically. The shadow array keeps its contents across reset and holds `SHADOW_INIT` in every byte at power-up.

The block oversamples SCL and SDA with the system clock. It pulls SDA low through `sda_oe` and never stretches the clock.

Top module: `i2c_cfg_target`

## Requirements
- R1: A frame of address (R/W = 0), command byte with bits [1:0] = 00, register index, then data bytes stores each data byte at the pointer. Every byte is acknowledged, and the new values appear on the side read port.
- R2: The register pointer advances by one after every data byte written or read, and it wraps from NREG-1 to 0.
- R3: An address byte with R/W = 1 yields ID_CODE first. Register bytes follow from the pointer for as long as the master acknowledges. The start index can be set by a command-00 frame carrying only an index, followed by a repeated START.
- R4: An address byte whose upper seven bits differ from DEV_ADDR is not acknowledged, whatever its R/W bit.
- R5: Command bits [1:0] = 01 copy every register into the shadow array, and `busy` rises right after the STOP that closes the frame.
- R6: Command bits [1:0] = 10 copy every shadow byte back into its register once STOP is seen.
- R7: A copy keeps `busy` high for exactly NREG*COPY_LAT cycles. While `busy` is high, the target address goes unacknowledged.
- R8: `busy` is high out of reset, and the bank is then loaded from the shadow array. The shadow contents survive reset and start at SHADOW_INIT in every byte.
- R9: Command bits [1:0] = 11 are acknowledged, start no copy and leave every register unchanged.
- R10: A read frame with no preceding index continues from the register after the last one accessed in an earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a restore |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | When high, the bus data line is pulled low |
| reg_rd_idx | input | $clog2(NREG) | Register index for the side read port |
| reg_rd_data | output | 8 | Register contents at `reg_rd_idx` |
| busy | output | 1 | A save or restore is in progress |

## Verification
A pointer or state register that slips by one shows up on the bus within one byte. A wrong identification byte or a shifted register sequence appears in the very next read frame, and a missing or extra acknowledge shows up at the ninth clock of the affected byte. Faults in the copy engine stay hidden until a later restore or reset brings the shadow contents back into the bank. The bench therefore saves, overwrites, restores and resets before it compares the side read port, and it times `busy` to the cycle.

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         NREG        = 8,
  parameter int         COPY_LAT    = 4,
  parameter logic [7:0] ID_CODE     = 8'hC3,
  parameter logic [7:0] SHADOW_INIT = 8'h5A,
  localparam int        IW          = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int        LW          = (COPY_LAT > 1) ? $clog2(COPY_LAT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [IW-1:0] reg_rd_idx,
  output logic [7:0]    reg_rd_data,
  output logic          busy
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;

  st_t           st;
  logic [2:0]    scl_p, sda_p;
  logic [3:0]    bcnt;
  logic [1:0]    bno;
  logic [7:0]    sh, tx;
  logic [1:0]    cmd;
  logic          rw, pend, nack;
  logic [IW-1:0] ptr, ptr_nxt, idx_in;
  logic          cp_res;
  logic [IW-1:0] cp_idx;
  logic [LW-1:0] lat;
  logic [7:0]    regs   [NREG];
  logic [7:0]    shadow [NREG] = '{default: SHADOW_INIT};

  wire scl_s     = scl_p[1];
  wire sda_s     = sda_p[1];
  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire start_det = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
  wire stop_det  = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];
  wire rx_done   = (st == S_RX) && scl_fall && (bcnt == 4'd8);
  wire host_we   = rx_done && (bno == 2'd3) && (cmd == 2'b00);
  wire step      = busy && (lat == LW'(COPY_LAT - 1));

  assign ptr_nxt     = (ptr == IW'(NREG - 1)) ? '0 : ptr + 1'b1;
  assign idx_in      = (int'(sh) < NREG) ? sh[IW-1:0] : '0;
  assign reg_rd_data = regs[reg_rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sda_oe <= 1'b0; bcnt <= '0; bno <= '0;
      sh <= '0; tx <= '0; cmd <= '0; rw <= 1'b0; pend <= 1'b0;
      nack <= 1'b0; ptr <= '0;
    end else if (start_det) begin
      st <= S_RX; bcnt <= '0; bno <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; sda_oe <= 1'b0; pend <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bcnt < 4'd8) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 1'b1;
          end else if (rx_done) begin
            bcnt <= '0;
            if (bno == 2'd0) begin
              if (sh[7:1] == DEV_ADDR && !busy) begin
                rw <= sh[0]; sda_oe <= 1'b1; st <= S_ACK; bno <= 2'd1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= S_ACK;
              if (bno != 2'd3) bno <= bno + 1'b1;
              if (bno == 2'd1) begin
                cmd  <= sh[1:0];
                pend <= sh[1] ^ sh[0];
              end
              if (bno == 2'd2 && cmd == 2'b00) ptr <= idx_in;
              if (host_we) ptr <= ptr_nxt;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          if (rw) begin
            tx <= ID_CODE; sda_oe <= ~ID_CODE[7]; bcnt <= '0; st <= S_TX;
          end else begin
            sda_oe <= 1'b0; st <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bcnt == 4'd7) begin
            sda_oe <= 1'b0; st <= S_MACK;
          end else begin
            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; bcnt <= bcnt + 1'b1;
          end
        end
        S_MACK: begin
          if (scl_rise) nack <= sda_s;
          else if (scl_fall) begin
            if (!nack) begin
              tx <= regs[ptr]; sda_oe <= ~regs[ptr][7]; ptr <= ptr_nxt;
              bcnt <= '0; st <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1; cp_res <= 1'b1; cp_idx <= '0; lat <= '0;
    end else if (busy) begin
      if (step) begin
        lat <= '0;
        if (cp_idx == IW'(NREG - 1)) begin
          busy <= 1'b0; cp_idx <= '0;
        end else begin
          cp_idx <= cp_idx + 1'b1;
        end
      end else begin
        lat <= lat + 1'b1;
      end
    end else if (stop_det && pend) begin
      busy <= 1'b1; cp_res <= cmd[1]; cp_idx <= '0; lat <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (step && !cp_res) shadow[cp_idx] <= regs[cp_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (step && cp_res) begin
      regs[cp_idx] <= shadow[cp_idx];
    end else if (host_we) begin
      regs[ptr] <= sh;
    end
  end

endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk #(
  parameter int NREG     = 8,
  parameter int COPY_LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic stop_det,
  input logic pend
);

  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (busy) run <= run + 1;
    else run <= 0;
  end

  AST_SDA_CHANGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R1

  AST_COPY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det && pend)); // R5

  AST_COPY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(run) == NREG * COPY_LAT - 1); // R7

  AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R7

endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(.NREG(NREG), .COPY_LAT(COPY_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_p[1]), .sda_oe(sda_oe), .busy(busy),
  .stop_det(stop_det), .pend(pend)
);

// File: tb/sim_i2c_cfg_target.sv
`timescale 1ns/1ps
module sim_i2c_cfg_target;
  localparam int NREG = 8;
  localparam int LAT  = 64;
  localparam int H    = 16;
  localparam logic [6:0] ADR = 7'h52;
  localparam logic [7:0] IDC = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, busy;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_data;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, errors = 0, run = 0, last_len = 0;
  bit done = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] shm [NREG];
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  event got;

  always #2 clk = ~clk;

  i2c_cfg_target #(.DEV_ADDR(ADR), .NREG(NREG), .COPY_LAT(LAT), .ID_CODE(IDC),
    .SHADOW_INIT(8'h5A)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_rd_idx(rd_idx), .reg_rd_data(rd_data), .busy(busy));

  always @(posedge clk) begin
    if (busy) run <= run + 1;
    else if (run != 0) begin last_len <= run; run <= 0; end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always begin
    @(got);
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), int'(act_q.pop_front()), int'(exp_q.pop_front()));
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic start();
    m_sda = 1; wt(H); m_scl = 1; wt(H); m_sda = 0; wt(H); m_scl = 0; wt(4);
  endtask

  task automatic stop();
    m_sda = 0; wt(H); m_scl = 1; wt(H); m_sda = 1; wt(H);
  endtask

  task automatic send(logic [7:0] b, bit exp_ack, string req);
    bit a;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(H); m_scl = 1; wt(H); m_scl = 0; wt(4);
    end
    m_sda = 1; wt(H); m_scl = 1; wt(H/2); a = !sda_bus; wt(H/2); m_scl = 0; wt(4);
    check(req, a, exp_ack);
  endtask

  task automatic recv(bit ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      wt(H); m_scl = 1; wt(H/2); b = {b[6:0], sda_bus}; wt(H/2); m_scl = 0; wt(4);
    end
    m_sda = ack ? 1'b0 : 1'b1; wt(H); m_scl = 1; wt(H); m_scl = 0; wt(4); m_sda = 1;
  endtask

  task automatic read_frame(int n, int from, string req);
    logic [7:0] v;
    exp_q.push_back(IDC); tag_q.push_back({req, " id byte"});
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mdl[(from + k) % NREG]); tag_q.push_back(req);
    end
    start(); send({ADR, 1'b1}, 1, req);
    for (int k = 0; k <= n; k++) begin
      recv(k != n, v); act_q.push_back(v); -> got;
    end
    stop();
  endtask

  task automatic write_regs(int idx, int n, int base, int stepv, string req);
    start(); send({ADR, 1'b0}, 1, req); send(8'h00, 1, req); send(8'(idx), 1, req);
    for (int k = 0; k < n; k++) begin
      send(8'(base + k * stepv), 1, req);
      mdl[(idx + k) % NREG] = 8'(base + k * stepv);
    end
    stop();
  endtask

  task automatic port_all(string req);
    for (int i = 0; i < NREG; i++) begin
      rd_idx = 3'(i); wt(2); check(req, rd_data, mdl[i]);
    end
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 5000) begin wt(1); n++; end
    check(req, busy, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin mdl[i] = 8'h5A; shm[i] = 8'h5A; end
    wt(10); rst_n = 1; wt(1);
    check("R8 busy out of reset", busy, 1);
    wait_idle("R8 restore ends");
    port_all("R8 bank from shadow");

    write_regs(2, 3, 8'h11, 8'h11, "R1");
    port_all("R1 side port");
    write_regs(6, 3, 8'h66, 8'h11, "R2");
    port_all("R2 wrap");

    start(); send({ADR, 1'b0}, 1, "R3"); send(8'h00, 1, "R3"); send(8'h05, 1, "R3");
    exp_q.push_back(IDC); tag_q.push_back("R3 id byte");
    for (int k = 0; k < 4; k++) begin exp_q.push_back(mdl[(5 + k) % NREG]); tag_q.push_back("R3"); end
    start(); send({ADR, 1'b1}, 1, "R3");
    for (int k = 0; k <= 4; k++) begin
      logic [7:0] v;
      recv(k != 4, v); act_q.push_back(v); -> got;
    end
    stop();

    read_frame(1, 1, "R10");

    start(); send({7'h53, 1'b0}, 0, "R4 write addr"); stop();
    start(); send({7'h53, 1'b1}, 0, "R4 read addr"); stop();

    start(); send({ADR, 1'b0}, 1, "R5"); send(8'h01, 1, "R5"); stop();
    check("R5 busy after stop", busy, 1);
    start(); send({ADR, 1'b0}, 0, "R7 no ack while busy"); stop();
    wait_idle("R5 save ends");
    wt(2);
    check("R7 copy length", last_len, NREG * LAT);
    for (int i = 0; i < NREG; i++) shm[i] = mdl[i];

    write_regs(0, NREG, 8'hF0, 1, "R6 overwrite");
    port_all("R6 overwrite");
    start(); send({ADR, 1'b0}, 1, "R6"); send(8'h02, 1, "R6"); stop();
    wait_idle("R6 restore ends");
    for (int i = 0; i < NREG; i++) mdl[i] = shm[i];
    port_all("R6 bank restored");

    start(); send({ADR, 1'b0}, 1, "R9"); send(8'h03, 1, "R9 ack"); stop();
    wt(40);
    check("R9 no copy", busy, 0);
    port_all("R9 bank unchanged");

    write_regs(3, 1, 8'hEE, 0, "R8 dirty");
    wt(4); rst_n = 0; wt(4); rst_n = 1; wt(1);
    check("R8 busy after reset", busy, 1);
    wait_idle("R8 second restore");
    for (int i = 0; i < NREG; i++) mdl[i] = shm[i];
    port_all("R8 shadow kept");

    wt(20); -> got; wt(2);
    check("scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule